// File: doc/BRIEF.md
# Serial Perfect-Shuffle Permutation Network

This block takes a serial stream of frames, each of N = 2^M words, one word per clock, and emits every frame in perfect-shuffle order. Within each frame the output alternates between the two halves of the input. The first half supplies the even output slots and the second half supplies the odd ones, so input words k and k+N/2 leave next to each other. The reordering uses no frame buffer and no crossbar. It runs through a cascade of M-1 serial exchange stages, with spans N/4, N/8, ..., 1.

Each exchange stage has a delay line as deep as its span and a pair of 2:1 multiplexers. Inside every group of four spans of the incoming stream, the stage trades the second span with the third and leaves the first and fourth in place. A stage hands on the group to the next stage after one span of delay. The whole cascade plus one output register gives a fixed latency of exactly N/2 cycles. A valid flag and a frame-start flag travel alongside the data with that same delay.

Each stage has a small controller with two states. ST_IDLE means no frame is in flight. ST_RUN means the stage is inside a frame and is counting word positions. Transitions:
- IDLE->RUN when a valid word carries the frame-start flag.
- RUN->RUN (restart) when a new frame-start arrives.
- RUN->IDLE after the valid word at position N-1.

The stage swaps only while it is in ST_RUN, and only at the positions where its span's two selection bits read binary 10.

Top module: `shuf_perm_net`

## Requirements
- R1: While reset is asserted, and until the first frame arrives, `out_valid` and `out_sof` are 0.
- R2: For a frame whose first word (position 0) is flagged by `in_sof`, output position p carries input position p/2 when p is even, and input position (p-1)/2 + N/2 when p is odd. Equivalently, input position i leaves at position (i rotated left by one bit over M bits).
- R3: `out_valid` and `out_sof` equal `in_valid` and (`in_valid` and `in_sof`) from exactly N/2 cycles earlier. For M=4 this is 8 cycles.
- R4: Frames presented back to back with no idle cycle between them are each permuted correctly. The output is then a continuous valid stream with no break inside a frame.
- R5: Any number of idle cycles between frames is accepted, and the frame after a gap is permuted correctly.
- R6: The word flagged by `out_sof` is the word that was flagged by `in_sof` (position 0 maps to itself).
- R7: `out_sof` is never high while `out_valid` is low.
- R8: The value on `in_data` during a cycle with `in_valid` low does not appear on the output and does not affect any later frame. The output shows `out_valid` low in the matching output cycle.
- R9: `in_sof` high in a cycle with `in_valid` low is ignored. No `out_sof` results from it, and the frame in flight is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_sof | input | 1 | Marks the first word of an input frame |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Output word valid |
| out_sof | output | 1 | Marks the first word of an output frame |
| out_data | output | DATA_W | Output word in shuffled order |

## Verification
The checker's properties take three things for granted about the input:
- a frame is exactly N words;
- the words of a frame arrive on consecutive cycles, starting with the word that carries `in_sof`;
- a new frame-start never lands inside a frame.

The random stimulus keeps within these assumptions by construction. Frames are always written in full as contiguous runs. Random-length idle gaps are inserted only between frames. Stray `in_sof` values and arbitrary data are placed only on cycles where `in_valid` is low.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xchg_state_e;

    // Span (delay depth) of exchange stage s in a cascade for 2^m points.
    function automatic int stage_span(input int m, input int s);
        return 1 << (m - 2 - s);
    endfunction

endpackage

// File: rtl/shuf_delay_line.sv
module shuf_delay_line #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] taps [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                taps[i] <= '0;
            end
        end else begin
            taps[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end

    assign dout = taps[DEPTH-1];

endmodule

// File: rtl/shuf_xchg_stage.sv
module shuf_xchg_stage import shuf_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int M      = 4,
    parameter int SPAN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    input  logic              i_sof,
    input  logic [DATA_W-1:0] i_data,
    output logic              o_valid,
    output logic              o_sof,
    output logic [DATA_W-1:0] o_data
);

    localparam int LK = $clog2(SPAN);
    localparam logic [M-1:0] LAST_POS = {M{1'b1}};

    xchg_state_e       st_q, st_d;
    logic [M-1:0]      pos_q, pos_d;
    logic              exch;
    logic [DATA_W-1:0] line_in, line_out;
    logic [1:0]        flag_out;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
        end
    end

    // Next state and position
    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        unique case (st_q)
            ST_IDLE: begin
                if (i_valid && i_sof) begin
                    st_d  = ST_RUN;
                    pos_d = M'(1);
                end
            end
            ST_RUN: begin
                if (i_valid) begin
                    if (i_sof) begin
                        pos_d = M'(1);
                    end else if (pos_q == LAST_POS) begin
                        st_d  = ST_IDLE;
                        pos_d = '0;
                    end else begin
                        pos_d = pos_q + M'(1);
                    end
                end
            end
            default: begin
                st_d  = ST_IDLE;
                pos_d = '0;
            end
        endcase
    end

    // Outputs: swap the third span of each four-span group with the second
    always_comb begin
        exch    = (st_q == ST_RUN) && i_valid && !i_sof &&
                  (pos_q[LK+1:LK] == 2'b10);
        line_in = exch ? line_out : i_data;
        o_data  = exch ? i_data : line_out;
        o_valid = flag_out[1];
        o_sof   = flag_out[0];
    end

    shuf_delay_line #(.WIDTH(DATA_W), .DEPTH(SPAN)) u_data_line (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .dout (line_out)
    );

    shuf_delay_line #(.WIDTH(2), .DEPTH(SPAN)) u_flag_line (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({i_valid, i_valid & i_sof}),
        .dout (flag_out)
    );

endmodule

// File: rtl/shuf_perm_net.sv
module shuf_perm_net import shuf_pkg::*; #(
    parameter int M      = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic [DATA_W-1:0] out_data
);

    localparam int STAGES = M - 1;

    logic [DATA_W-1:0] d_chain [STAGES+1];
    logic [STAGES:0]   v_chain;
    logic [STAGES:0]   s_chain;

    assign d_chain[0] = in_data;
    assign v_chain[0] = in_valid;
    assign s_chain[0] = in_valid & in_sof;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        shuf_xchg_stage #(
            .DATA_W(DATA_W),
            .M     (M),
            .SPAN  (stage_span(M, s))
        ) u_xchg (
            .clk    (clk),
            .rst_n  (rst_n),
            .i_valid(v_chain[s]),
            .i_sof  (s_chain[s]),
            .i_data (d_chain[s]),
            .o_valid(v_chain[s+1]),
            .o_sof  (s_chain[s+1]),
            .o_data (d_chain[s+1])
        );
    end

    // Output register cuts the bypass path of the exchange multiplexers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= v_chain[STAGES];
            out_sof   <= s_chain[STAGES];
            out_data  <= d_chain[STAGES];
        end
    end

endmodule

// File: rtl/shuf_perm_net_chk.sv
module shuf_perm_net_chk #(
    parameter int M      = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sof,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_sof,
    input logic [DATA_W-1:0] out_data
);

    localparam int N   = 1 << M;
    localparam int LAT = N / 2;
    localparam logic [M-1:0] LAST_POS = {M{1'b1}};

    logic [LAT-1:0]    vh, sh;
    logic [DATA_W-1:0] head_q;
    logic [M-1:0]      oc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vh     <= '0;
            sh     <= '0;
            head_q <= '0;
            oc     <= '0;
        end else begin
            vh <= (vh << 1) | LAT'(in_valid);
            sh <= (sh << 1) | LAT'(in_valid & in_sof);
            if (in_valid && in_sof) begin
                head_q <= in_data;
            end
            if (out_valid && out_sof) begin
                oc <= M'(1);
            end else if (out_valid && oc != '0) begin
                oc <= (oc == LAST_POS) ? '0 : oc + M'(1);
            end
        end
    end

    assert_flag_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == vh[LAT-1]) && (out_sof == sh[LAT-1]));

    assert_sof_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    assert_head_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_data == head_q));

    assert_no_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (oc != '0) |-> (out_valid && !out_sof));

endmodule

bind shuf_perm_net shuf_perm_net_chk #(.M(M), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_sof  (out_sof),
    .out_data (out_data)
);

// File: tb/shuf_perm_net_tb.sv
module shuf_perm_net_tb;

    localparam int M          = 4;
    localparam int DATA_W     = 16;
    localparam int N          = 1 << M;
    localparam int LAT        = N / 2;
    localparam int CLK_PERIOD = 10;
    localparam int NF         = 24;
    localparam int SZ         = 1024;
    localparam int WD_CYCLES  = 20000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid, in_sof;
    logic [DATA_W-1:0] in_data;
    logic              out_valid, out_sof;
    logic [DATA_W-1:0] out_data;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    bit                sv_valid [SZ];
    bit                sv_sof   [SZ];
    logic [DATA_W-1:0] sv_data  [SZ];
    bit                ev       [SZ];
    bit                es       [SZ];
    logic [DATA_W-1:0] ed       [SZ];
    int                etag     [SZ];
    int                n_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    shuf_perm_net #(.M(M), .DATA_W(DATA_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_sof  (out_sof),
        .out_data (out_data)
    );

    // Source position feeding output position p (R2)
    function automatic int src_pos(input int p);
        return (p >> 1) + ((p & 1) * (N / 2));
    endfunction

    function automatic string tname(input int t);
        case (t)
            2: return "R2";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            9: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog expired: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd715));
        for (int j = 0; j < SZ; j++) begin
            sv_valid[j] = 1'b0; sv_sof[j] = 1'b0; sv_data[j] = '0;
            ev[j] = 1'b0; es[j] = 1'b0; ed[j] = '0; etag[j] = 8;
        end
        n_in = 0;
        // Build the stimulus: directed frames first, then random ones
        for (int f = 0; f < NF; f++) begin
            int g, s;
            if (f < 4)       g = 0;
            else if (f == 4) g = 1;
            else if (f == 5) g = 6;
            else             g = $urandom_range(0, 3);
            for (int k = 0; k < g; k++) begin
                sv_valid[n_in] = 1'b0;
                sv_sof[n_in]   = (f == 5) ? 1'b1 : 1'($urandom_range(0, 1));
                sv_data[n_in]  = DATA_W'($urandom);
                etag[n_in+LAT] = sv_sof[n_in] ? 9 : 8;
                n_in++;
            end
            s = n_in;
            for (int p = 0; p < N; p++) begin
                sv_valid[n_in] = 1'b1;
                sv_sof[n_in]   = (p == 0);
                case (f)
                    0: sv_data[n_in] = DATA_W'(p);
                    1: sv_data[n_in] = DATA_W'(16'hA5A5 ^ p);
                    2: sv_data[n_in] = DATA_W'(1) << p;
                    default: sv_data[n_in] = DATA_W'($urandom);
                endcase
                n_in++;
            end
            for (int p = 0; p < N; p++) begin
                ev[s+p+LAT]   = 1'b1;
                es[s+p+LAT]   = (p == 0);
                ed[s+p+LAT]   = sv_data[s + src_pos(p)];
                etag[s+p+LAT] = (p == 0) ? 6 : (f < 4) ? 4 : (g > 0) ? 5 : 2;
            end
        end

        // Reset phase (R1)
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = '0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            vectors++;
            if (out_valid !== 1'b0 || out_sof !== 1'b0) begin
                fails++;
                $display("FAIL R1 reset outputs: actual valid=%b sof=%b expected 0 0",
                         out_valid, out_sof);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        for (int c = 0; c < n_in + LAT + 4; c++) begin
            @(negedge clk);
            vectors++;
            if (out_sof && !out_valid) begin
                fails++;
                $display("FAIL R7 cycle %0d: actual sof=1 valid=0 expected sof only with valid", c);
            end
            if (out_valid !== ev[c] || out_sof !== es[c]) begin
                fails++;
                $display("FAIL %s flags cycle %0d: actual valid=%b sof=%b expected valid=%b sof=%b",
                         (ev[c] ? "R3" : tname(etag[c])), c, out_valid, out_sof, ev[c], es[c]);
                if (c < LAT) begin
                    $display("FAIL R1 idle after reset cycle %0d: actual valid=%b expected 0",
                             c, out_valid);
                end
            end else if (ev[c] && out_data !== ed[c]) begin
                fails++;
                $display("FAIL %s data cycle %0d: actual %h expected %h",
                         tname(etag[c]), c, out_data, ed[c]);
            end
            if (c < n_in) begin
                in_valid = sv_valid[c];
                in_sof   = sv_sof[c];
                in_data  = sv_data[c];
            end else begin
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_data  = '0;
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule